// File: doc/BRIEF.md
# Power-Down Exit Output Sequencer

This block decides what the outputs of a multi-output clock generator do while the chip leaves power-down. It has an active-high power-down request, a raw PLL lock indication from another clock domain, and a slow timebase tick. From these it drives three signals: a three-state control for each output, one request that parks the differential outputs at their high level, and a clock enable for each output. The analog drivers, the PLL and the current references are outside the block. They see only these enables.

Leaving power-down takes three steps. First the outputs keep floating while the supply settles. After a set number of ticks they are driven to the parked high level. Once the lock indication has been synchronized and has stayed steady for long enough, the clocks are released in a fixed order, one output per clock cycle. A budget counter raises a timeout flag if lock has not been accepted when the total start-up allowance runs out. Raising power-down again at any time floats every output in the same cycle and sends the sequence back to its first step.

Top module: `pdx_seq`

## Requirements
- R1: After a synchronous reset with power-down low and no ticks, every bit of `out_hiz_o` is 1 and `park_hi_o`, `clk_en_o` and `timeout_o` are all 0.
- R2: While `pwr_down_i` is 1, in that same cycle and in every state, `out_hiz_o` is all ones and `clk_en_o`, `park_hi_o` and `timeout_o` are 0.
- R3: After power-down drops, the outputs keep floating until PARK_TICKS ticks (default 3) have been counted. On the clock cycle after that tick, `out_hiz_o` becomes all zeros and `park_hi_o` becomes 1. With fewer ticks the outputs stay floating.
- R4: No clock enable is set until lock has been accepted. To be accepted, `pll_lock_i` must pass two synchronizing flip-flops and then stay high across LOCK_TICKS consecutive ticks (default 4). A low level at any point restarts that count.
- R5: Clocks are released as a thermometer code that starts at bit 0 and adds one bit per cycle. The first enable appears two cycles after acceptance, and the last comes N_OUT-1 cycles after the first. `park_hi_o` falls once every enable is set.
- R6: `timeout_o` goes to 1 if TOTAL_TICKS ticks (default 12) pass after power-down exit without lock being accepted. It stays 1, even if a release happens later, until power-down is raised again. It stays 0 if 11 ticks pass without lock.
- R7: When power-down is raised and then dropped again, the sequence starts over: all outputs float again, with no enable set and no timeout.
- R8: After every output has been released, a later loss of `pll_lock_i` leaves all enables set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pwr_down_i | input | 1 | Power-down request, active high, synchronous to clk |
| tick_i | input | 1 | Timebase tick, one-cycle pulse |
| pll_lock_i | input | 1 | Raw PLL lock indication, asynchronous |
| out_hiz_o | output | N_OUT | Per-output three-state control, 1 = floating |
| park_hi_o | output | 1 | Request to drive the differential outputs to the parked high level |
| clk_en_o | output | N_OUT | Per-output clock enable |
| timeout_o | output | 1 | Start-up budget expired before lock was accepted |

## Verification
A stuck or wrong sequencer state shows at the ports within one or two cycles. Outputs can float after the park tick. Enables can rise before the outputs are parked. A release can leave a gap in the thermometer code or skip bits in one cycle. A fault in the tick or lock counters appears as a park or release that comes one tick early or one tick late. For this reason the checks place the tick counts exactly one below and exactly at each threshold. Faults in the power-down path appear in the very cycle the request is raised, because that path is combinational.

// File: rtl/pdx_pkg.sv
// Package: shared state type for the power-down exit sequencer.
// Assumes nothing beyond IEEE 1800-2017.
package pdx_pkg;

    // Sequencer phases, in the order they are traversed after power-down exit.
    typedef enum logic [1:0] {
        ST_FLOAT = 2'd0,   // outputs three-stated, supply settling
        ST_PARK  = 2'd1,   // outputs driven to parked high, awaiting lock
        ST_REL   = 2'd2,   // clocks being released one per cycle
        ST_RUN   = 2'd3    // all clocks running
    } seq_state_e;

endpackage

// File: rtl/pdx_tick_timer.sv
// Module: counts timebase ticks since power-down exit, saturating at the
// total start-up budget. Flags when the park point and the budget are reached.
// Assumes: tick_i is a single-cycle pulse; clear_i is synchronous.
module pdx_tick_timer #(
    parameter int unsigned PARK_TICKS  = 3,
    parameter int unsigned TOTAL_TICKS = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    output logic park_due_o,
    output logic budget_out_o
);
    localparam int unsigned W = $clog2(TOTAL_TICKS + 1);
    localparam logic [W-1:0] PARK_C = W'(PARK_TICKS);
    localparam logic [W-1:0] TOT_C  = W'(TOTAL_TICKS);

    logic [W-1:0] cnt_q;

    // Purpose: count ticks while out of power-down, stop at the budget.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != TOT_C)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: threshold decodes for the sequencer.
    always_comb begin
        park_due_o   = (cnt_q >= PARK_C);
        budget_out_o = (cnt_q == TOT_C);
    end
endmodule

// File: rtl/pdx_lock_qual.sv
// Module: brings the asynchronous lock indication into the clk domain with two
// flip-flops, then accepts it only after it has stayed high across LOCK_TICKS
// consecutive timebase ticks. Any low level restarts the count.
// Assumes: pll_lock_i may change at any time; tick_i is a single-cycle pulse.
module pdx_lock_qual #(
    parameter int unsigned LOCK_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic tick_i,
    input  logic pll_lock_i,
    output logic lock_ok_o
);
    localparam int unsigned W = $clog2(LOCK_TICKS + 1);
    localparam logic [W-1:0] LK_C = W'(LOCK_TICKS);

    logic          sync1_q;
    logic          sync2_q;
    logic [W-1:0]  stable_q;

    // Purpose: two-stage synchronizer for the raw lock level.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
        end else begin
            sync1_q <= pll_lock_i;
            sync2_q <= sync1_q;
        end
    end

    // Purpose: count ticks with lock steadily high, restart on any drop.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || !sync2_q) begin
            stable_q <= '0;
        end else if (tick_i && (stable_q != LK_C)) begin
            stable_q <= stable_q + 1'b1;
        end
    end

    // Purpose: lock accepted once the stable count is complete.
    assign lock_ok_o = sync2_q && (stable_q == LK_C);
endmodule

// File: rtl/pdx_release.sv
// Module: releases clock enables as a thermometer code, bit 0 first, one bit
// per cycle while step_i is high. This keeps the first-to-last skew at N_OUT-1
// cycles.
// Assumes: step_i stays high until full_o is seen.
module pdx_release #(
    parameter int unsigned N_OUT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [N_OUT-1:0] en_o,
    output logic             full_o
);
    localparam logic [N_OUT-1:0] ONE_C = N_OUT'(1);

    logic [N_OUT-1:0] en_q;

    // Purpose: shift one more enable in per cycle of stepping.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            en_q <= '0;
        end else if (step_i) begin
            en_q <= (en_q << 1) | ONE_C;
        end
    end

    // Purpose: present the enables and the all-released flag.
    assign en_o   = en_q;
    assign full_o = &en_q;
endmodule

// File: rtl/pdx_seq.sv
// Module: top of the power-down exit sequencer. The outputs float, then park
// high after PARK_TICKS ticks. Once lock has been accepted they are released one
// per cycle. A timeout flag marks a start-up budget that ran out before lock.
// The power-down request reaches the outputs combinationally, so they float in
// the cycle it is raised. Registered state is cleared at the next edge.
// Assumes: pwr_down_i is synchronous to clk; PARK_TICKS < TOTAL_TICKS.
module pdx_seq
    import pdx_pkg::*;
#(
    parameter int unsigned N_OUT       = 6,
    parameter int unsigned PARK_TICKS  = 3,
    parameter int unsigned TOTAL_TICKS = 12,
    parameter int unsigned LOCK_TICKS  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_down_i,
    input  logic             tick_i,
    input  logic             pll_lock_i,
    output logic [N_OUT-1:0] out_hiz_o,
    output logic             park_hi_o,
    output logic [N_OUT-1:0] clk_en_o,
    output logic             timeout_o
);
    seq_state_e       state_q;
    seq_state_e       state_d;
    logic             park_due;
    logic             budget_out;
    logic             lock_ok;
    logic             rel_full;
    logic [N_OUT-1:0] rel_en;
    logic             timeout_q;

    pdx_tick_timer #(
        .PARK_TICKS  (PARK_TICKS),
        .TOTAL_TICKS (TOTAL_TICKS)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (pwr_down_i),
        .tick_i       (tick_i),
        .park_due_o   (park_due),
        .budget_out_o (budget_out)
    );

    pdx_lock_qual #(
        .LOCK_TICKS (LOCK_TICKS)
    ) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (pwr_down_i),
        .tick_i     (tick_i),
        .pll_lock_i (pll_lock_i),
        .lock_ok_o  (lock_ok)
    );

    pdx_release #(
        .N_OUT (N_OUT)
    ) u_rel (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (pwr_down_i),
        .step_i  (state_q == ST_REL),
        .en_o    (rel_en),
        .full_o  (rel_full)
    );

    // Purpose: next-phase decision of the exit sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FLOAT: if (park_due) state_d = ST_PARK;
            ST_PARK:  if (lock_ok)  state_d = ST_REL;
            ST_REL:   if (rel_full) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_FLOAT;
        endcase
    end

    // Purpose: phase register, back to floating on reset or power-down.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down_i) begin
            state_q <= ST_FLOAT;
        end else begin
            state_q <= state_d;
        end
    end

    // Purpose: sticky flag for a start-up budget spent before lock acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down_i) begin
            timeout_q <= 1'b0;
        end else if (budget_out && (state_q == ST_FLOAT || state_q == ST_PARK)) begin
            timeout_q <= 1'b1;
        end
    end

    // Purpose: output drive, with power-down overriding every phase at once.
    always_comb begin
        out_hiz_o = (pwr_down_i || state_q == ST_FLOAT) ? '1 : '0;
        park_hi_o = !pwr_down_i && (state_q == ST_PARK || state_q == ST_REL);
        clk_en_o  = pwr_down_i ? '0 : rel_en;
        timeout_o = timeout_q && !pwr_down_i;
    end
endmodule

// File: rtl/pdx_seq_chk.sv
// Module: port-level property checker for pdx_seq, attached through bind.
// Assumes: the same N_OUT as the bound instance.
module pdx_seq_chk #(
    parameter int unsigned N_OUT = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwr_down_i,
    input logic [N_OUT-1:0] out_hiz_o,
    input logic             park_hi_o,
    input logic [N_OUT-1:0] clk_en_o,
    input logic             timeout_o
);
    // R2: power-down forces float and quiet outputs in the same cycle.
    a_r2_pd_float: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_i |-> ((&out_hiz_o) && (clk_en_o == '0) && !park_hi_o && !timeout_o));

    // R3: parked drive never coexists with a floating output.
    a_r3_park_driven: assert property (@(posedge clk) disable iff (!rst_n)
        park_hi_o |-> (out_hiz_o == '0));

    // R4: the first enable only rises out of the parked phase.
    a_r4_release_from_park: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|clk_en_o) |-> $past(park_hi_o));

    // R5: enables form a thermometer code from bit 0.
    a_r5_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_en_o & (clk_en_o + N_OUT'(1))) == '0));

    // R5: at most one new enable per cycle.
    a_r5_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_down_i |=> ($countones(clk_en_o) <= $countones($past(clk_en_o)) + 1));

    // R5: an enabled clock always has its output driven.
    a_r5_en_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (|clk_en_o) |-> (out_hiz_o == '0));

    // R6: timeout stays set until power-down.
    a_r6_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_o && !pwr_down_i) |=> (timeout_o || pwr_down_i));
endmodule

bind pdx_seq pdx_seq_chk #(.N_OUT(N_OUT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_down_i (pwr_down_i),
    .out_hiz_o  (out_hiz_o),
    .park_hi_o  (park_hi_o),
    .clk_en_o   (clk_en_o),
    .timeout_o  (timeout_o)
);

// File: tb/pdx_seq_bench.sv
// Bench: a vector table of exit scenarios walked by one loop, then directed
// tests for reset, the release order, lock glitches, lock loss and power-down.
module pdx_seq_bench;
    localparam int unsigned N   = 6;
    localparam int unsigned PKT = 3;
    localparam int unsigned TOT = 12;
    localparam int unsigned LKT = 4;

    // Row fields: [15:12] ticks before lock, [11:8] ticks with lock,
    // [7] lock level, [3] expect floating, [2] expect parked-not-running,
    // [1] expect all enables, [0] expect timeout.
    localparam logic [15:0] VEC [8] = '{
        16'h0482,  // R4 lock early, 4 ticks: released
        16'h2008,  // R3 2 ticks: still floating
        16'h3004,  // R3 3 ticks: parked
        16'h0288,  // R4 only 2 qualified ticks: floating, no enable
        16'hC005,  // R6 budget spent: timeout
        16'hB004,  // R6 one tick short: no timeout
        16'h9483,  // R6 late lock: released, timeout kept
        16'h6482   // R5 lock in budget: released, no timeout
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pwr_down = 1'b0;
    logic         tick = 1'b0;
    logic         lock = 1'b0;
    logic [N-1:0] hiz;
    logic         park;
    logic [N-1:0] en;
    logic         tout;

    int total = 0;
    int bad = 0;
    int first_at;
    int full_at;
    logic ok_th;
    logic ok_step;
    logic [N-1:0] prev;

    always #2 clk = ~clk;

    pdx_seq #(.N_OUT(N), .PARK_TICKS(PKT), .TOTAL_TICKS(TOT), .LOCK_TICKS(LKT)) u_pdx_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_down_i (pwr_down),
        .tick_i     (tick),
        .pll_lock_i (lock),
        .out_hiz_o  (hiz),
        .park_hi_o  (park),
        .clk_en_o   (en),
        .timeout_o  (tout)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic pd_cycle();
        @(negedge clk) pwr_down = 1'b1;
        @(negedge clk) pwr_down = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        cyc(3);
        chk("R1 hiz", 32'(hiz), 32'(N'('1)));
        chk("R1 park", 32'(park), 0);
        chk("R1 en", 32'(en), 0);
        chk("R1 timeout", 32'(tout), 0);
        @(negedge clk) rst_n = 1'b1;

        // Table walk
        for (int r = 0; r < 8; r++) begin
            lock = 1'b0;
            pd_cycle();
            pulse_tick(int'(VEC[r][15:12]));
            lock = VEC[r][7];
            cyc(3);
            pulse_tick(int'(VEC[r][11:8]));
            cyc(N + 4);
            chk($sformatf("R3/R4 row%0d hiz", r), 32'(hiz), VEC[r][3] ? 32'(N'('1)) : 0);
            chk($sformatf("R3/R5 row%0d park", r), 32'(park), 32'(VEC[r][2]));
            chk($sformatf("R4/R5 row%0d en", r), 32'(en), VEC[r][1] ? 32'(N'('1)) : 0);
            chk($sformatf("R6 row%0d timeout", r), 32'(tout), 32'(VEC[r][0]));
        end

        // R3: park exactly one cycle after the PARK_TICKS-th tick
        lock = 1'b0;
        pd_cycle();
        pulse_tick(PKT - 1);
        cyc(4);
        chk("R3 before park tick", 32'(hiz), 32'(N'('1)));
        pulse_tick(1);
        chk("R3 same cycle as tick", 32'(hiz), 32'(N'('1)));
        cyc(1);
        chk("R3 parked next cycle", 32'(hiz), 0);
        chk("R3 park request", 32'(park), 1);

        // R5: release order and skew
        lock = 1'b1;
        cyc(3);
        pulse_tick(LKT);
        first_at = -1;
        full_at = -1;
        ok_th = 1'b1;
        ok_step = 1'b1;
        prev = '0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (en != '0 && first_at < 0) first_at = c;
            if (((en + N'(1)) & en) != '0) ok_th = 1'b0;
            if ($countones(en) > $countones(prev) + 1) ok_step = 1'b0;
            if ((&en) && full_at < 0) full_at = c;
            prev = en;
        end
        chk("R5 first enable delay", 32'(first_at), 1);
        chk("R5 thermometer", 32'(ok_th), 1);
        chk("R5 one per cycle", 32'(ok_step), 1);
        chk("R5 skew", 32'(full_at - first_at), N - 1);
        chk("R5 park released", 32'(park), 0);

        // R8: lock loss after release has no effect
        lock = 1'b0;
        cyc(6);
        chk("R8 enables kept", 32'(en), 32'(N'('1)));

        // R2: power-down in the running state, same cycle
        @(negedge clk) pwr_down = 1'b1;
        #1;
        chk("R2 hiz", 32'(hiz), 32'(N'('1)));
        chk("R2 en", 32'(en), 0);
        chk("R2 park", 32'(park), 0);

        // R7: restart from floating
        @(negedge clk) pwr_down = 1'b0;
        cyc(3);
        chk("R7 hiz", 32'(hiz), 32'(N'('1)));
        chk("R7 en", 32'(en), 0);

        // R4: lock glitch restarts qualification
        pulse_tick(PKT);
        lock = 1'b1;
        cyc(3);
        pulse_tick(2);
        lock = 1'b0;
        cyc(3);
        lock = 1'b1;
        cyc(3);
        pulse_tick(LKT - 1);
        cyc(N + 4);
        chk("R4 glitch restarts count", 32'(en), 0);
        pulse_tick(1);
        cyc(N + 4);
        chk("R4 accepted after full count", 32'(en), 32'(N'('1)));
        chk("R6 no timeout inside budget", 32'(tout), 0);

        // R2/R6: timeout cleared in the power-down cycle
        lock = 1'b0;
        pd_cycle();
        pulse_tick(TOT);
        cyc(2);
        chk("R6 timeout set", 32'(tout), 1);
        @(negedge clk) pwr_down = 1'b1;
        #1;
        chk("R2 timeout masked", 32'(tout), 0);
        @(negedge clk) pwr_down = 1'b0;
        cyc(2);
        chk("R7 timeout cleared", 32'(tout), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule